// File: doc/BRIEF.md
# Zoned Decimal Address Translator with Index Fetch

This block turns a three-character decimal operand address into a binary character address between 0 and 15999. Each character is six bits: two zone bits over a BCD digit. The three digits give the address within a block of one thousand. Zone bits on the first and last characters pick one of sixteen thousand-blocks. The zone bits on the middle character select an optional index register.

When an index register is selected, its value sits in three consecutive memory cells at a fixed location. The block reads those three characters, one per cycle, over a simple read port. It decodes them the same way as the address and adds the result to the base address, wrapping at 16000. The effective address is presented with a one-cycle done pulse. The block is used between an instruction fetch unit, which supplies the address characters, and the memory, which it borrows for the index reads.

Top module: `dax_addr_xlate`

## Requirements
- R1: While reset is high and after it is released, `done`, `busy` and `mem_rd` are 0 and `ea` is 0.
- R2: Character bit 5 and bit 4 form the zone (bit 5 high), and bits 3:0 hold a BCD digit. The base address is thousands*1000 + digit(first)*100 + digit(middle)*10 + digit(last).
- R3: The thousands value is the 4-bit number {first char bits 5:4, last char bits 5:4}, giving 0 to 15.
- R4: A digit code of 4'b1010 counts as 0.
- R5: With middle zone 2'b00, no memory read occurs. `done` is high in the cycle right after the edge that samples `start`, with `ea` equal to the base address.
- R6: With middle zone 1, 2 or 3, the block reads addresses 87-89, 92-94 or 97-99, respectively. The reads go in ascending order, one per cycle, starting in the cycle after `start` is sampled. Read data is taken one cycle after `mem_rd`.
- R7: The index value is decoded as in R2 to R4 from the three characters read, with the lowest address acting as the first character and the middle character's zone ignored. `ea` = (base + index) mod 16000.
- R8: In the indexed case, `busy` is high for four cycles starting right after the sampling edge. `done` rises four cycles later than in R5, in the cycle where `busy` has just fallen.
- R9: `start` is ignored while `busy` is high: no extra `done`, no change of the result, no extra reads.
- R10: `done` lasts one cycle, and `ea` holds its value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a translation of the three characters |
| char_hi | input | 6 | First (hundreds) address character |
| char_mid | input | 6 | Middle (tens) character; zone selects index |
| char_lo | input | 6 | Last (units) character |
| mem_rd | output | 1 | Memory read request for an index character |
| mem_addr | output | 14 | Address of the index character being read |
| mem_rdata | input | 6 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Index fetch in progress |
| done | output | 1 | One-cycle pulse: `ea` is valid |
| ea | output | 14 | Effective binary address |

## Verification
The bench pushes the thousands field to its extremes. It sets all four zone bits to get 15999, and uses mixed zone pairs that expose a swapped or reversed bit order. It feeds the 1010 digit code, which a plain BCD decoder would read as ten. It selects each of the three index slots. Reading the wrong slot, reading in the wrong order, or letting the middle index character's zone into the thousands would all change the sum. It also makes a sum exceed 16000, which shows a missing wrap, and raises `start` during a fetch. A design that accepted that second start would emit an early done or clobber the result.

// File: rtl/dax_pkg.sv
`timescale 1ns/1ps
package dax_pkg;
    localparam int CHAR_W     = 6;
    localparam int BCD_W      = 4;
    localparam int ADDR_W     = 14;
    localparam int SPAN       = 16000;
    localparam int IDX_CHARS  = 3;
    localparam int IDX_FIRST  = 87;
    localparam int IDX_STRIDE = 5;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        char_t hi;
        char_t mid;
        char_t lo;
    } addr_chars_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SUM   = 2'd2
    } fetch_state_e;

    function automatic logic [1:0] zone_of(input char_t c);
        return c[CHAR_W-1 -: 2];
    endfunction

    function automatic logic [BCD_W-1:0] digit_of(input char_t c);
        logic [BCD_W-1:0] d;
        d = c[BCD_W-1:0];
        return (d == 4'd10) ? 4'd0 : d;
    endfunction

    function automatic addr_t slot_base(input logic [1:0] sel);
        return addr_t'(IDX_FIRST + (int'(sel) - 1) * IDX_STRIDE);
    endfunction
endpackage

// File: rtl/dax_char_decode.sv
`timescale 1ns/1ps
module dax_char_decode
    import dax_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  addr_chars_t   chars,
    output logic [AW-1:0] value
);
    logic [3:0] thou;

    assign thou = {zone_of(chars.hi), zone_of(chars.lo)};

    always_comb begin
        value = AW'(int'(thou) * 1000
                  + int'(digit_of(chars.hi)) * 100
                  + int'(digit_of(chars.mid)) * 10
                  + int'(digit_of(chars.lo)));
    end
endmodule

// File: rtl/dax_wrap_add.sv
`timescale 1ns/1ps
module dax_wrap_add #(
    parameter int AW     = 14,
    parameter int SPAN_P = 16000
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW-1:0] sum
);
    logic [AW:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        if (raw >= (AW+1)'(SPAN_P))
            raw = raw - (AW+1)'(SPAN_P);
        sum = raw[AW-1:0];
    end
endmodule

// File: rtl/dax_idx_fetch.sv
`timescale 1ns/1ps
module dax_idx_fetch
    import dax_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [1:0]    sel,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  char_t         mem_rdata,
    output logic          busy,
    output logic          idx_ready,
    output addr_chars_t   idx_chars
);
    localparam int CW = $clog2(IDX_CHARS);

    fetch_state_e  st;
    logic [CW-1:0] cnt;
    logic [AW-1:0] slot;
    char_t         cap [IDX_CHARS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            slot <= '0;
        end else begin
            case (st)
                ST_IDLE: if (launch) begin
                    st   <= ST_FETCH;
                    cnt  <= '0;
                    slot <= AW'(slot_base(sel));
                end
                ST_FETCH: begin
                    if (cnt == CW'(IDX_CHARS - 1)) st <= ST_SUM;
                    else                           cnt <= cnt + CW'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // each read returns one cycle later; the last arrives in ST_SUM
    for (genvar k = 0; k < IDX_CHARS - 1; k++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)
                cap[k] <= '0;
            else if (st == ST_FETCH && cnt == CW'(k + 1))
                cap[k] <= mem_rdata;
        end
    end

    assign mem_rd    = (st == ST_FETCH);
    assign mem_addr  = slot + AW'(cnt);
    assign busy      = (st != ST_IDLE);
    assign idx_ready = (st == ST_SUM);
    assign idx_chars = '{hi: cap[0], mid: cap[1], lo: mem_rdata};

    // R6
    ready_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        idx_ready |-> $past(mem_rd));
endmodule

// File: rtl/dax_addr_xlate.sv
`timescale 1ns/1ps
module dax_addr_xlate
    import dax_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [5:0]    char_hi,
    input  logic [5:0]    char_mid,
    input  logic [5:0]    char_lo,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [5:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea
);
    addr_chars_t   in_chars;
    addr_chars_t   idx_chars;
    logic [AW-1:0] base_val;
    logic [AW-1:0] base_q;
    logic [AW-1:0] idx_val;
    logic [AW-1:0] sum_val;
    logic [1:0]    sel;
    logic          accept;
    logic          launch;
    logic          idx_ready;

    assign in_chars = '{hi: char_hi, mid: char_mid, lo: char_lo};
    assign sel      = zone_of(char_mid);
    assign accept   = start && !busy;
    assign launch   = accept && (sel != 2'd0);

    dax_char_decode #(.AW(AW)) u_base_dec (.chars(in_chars),  .value(base_val));
    dax_char_decode #(.AW(AW)) u_idx_dec  (.chars(idx_chars), .value(idx_val));

    dax_wrap_add #(.AW(AW), .SPAN_P(SPAN)) u_add (
        .a(base_q), .b(idx_val), .sum(sum_val));

    dax_idx_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst(rst), .launch(launch), .sel(sel),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .idx_ready(idx_ready), .idx_chars(idx_chars));

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            ea     <= '0;
            base_q <= '0;
        end else begin
            done <= 1'b0;
            if (launch)
                base_q <= base_val;
            if (accept && sel == 2'd0) begin
                ea   <= base_val;
                done <= 1'b1;
            end
            if (idx_ready) begin
                ea   <= sum_val;
                done <= 1'b1;
            end
        end
    end

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + AW'(1));

    // R6
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr >= AW'(87) && mem_addr <= AW'(99) && (mem_addr % AW'(5)) >= AW'(2)));

    // R8
    done_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7
    ea_in_span_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ea < AW'(SPAN));
endmodule

// File: tb/dax_addr_xlate_tb.sv
`timescale 1ns/1ps
module dax_addr_xlate_tb;
    import dax_pkg::*;

    logic  clk = 1'b0;
    logic  rst;
    logic  start;
    char_t c_hi, c_mid, c_lo;
    logic  mem_rd;
    addr_t mem_addr;
    char_t mem_rdata;
    logic  busy, done;
    addr_t ea;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dax_addr_xlate u_dut (
        .clk(clk), .rst(rst), .start(start),
        .char_hi(c_hi), .char_mid(c_mid), .char_lo(c_lo),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ea(ea));

    // memory model: data one cycle after the read request
    char_t mem [0:127];
    int    rd_total = 0;
    addr_t rd_log [0:15];

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata             <= mem[mem_addr[6:0]];
            rd_log[rd_total & 15] <= mem_addr;
            rd_total              <= rd_total + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int dig(input char_t c);
        return (c[3:0] == 4'd10) ? 0 : int'(c[3:0]);
    endfunction

    function automatic int ref_val(input char_t a, input char_t b, input char_t c);
        return int'({a[5:4], c[5:4]}) * 1000 + dig(a) * 100 + dig(b) * 10 + dig(c);
    endfunction

    function automatic int slot_of(input char_t mid);
        case (mid[5:4])
            2'd1:    return 87;
            2'd2:    return 92;
            2'd3:    return 97;
            default: return 0;
        endcase
    endfunction

    task automatic set_slot(input int base, input char_t a, input char_t b, input char_t c);
        mem[base] = a; mem[base+1] = b; mem[base+2] = c;
    endtask

    task automatic do_op(input string req, input char_t h, input char_t m, input char_t l);
        int r0   = rd_total;
        int slot = slot_of(m);
        int lat  = 1;
        int exp  = ref_val(h, m, l);
        addr_t held;
        if (slot != 0)
            exp = (exp + ref_val(mem[slot], mem[slot+1], mem[slot+2])) % 16000;
        c_hi = h; c_mid = m; c_lo = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 12) begin
            check(req, "busy during op", int'(busy), (slot != 0) ? 1 : 0);
            @(negedge clk);
            lat++;
        end
        check(req, "done latency", lat, (slot != 0) ? 5 : 1);
        check(req, "ea", int'(ea), exp);
        check(req, "busy at done", int'(busy), 0);
        check(req, "read count", rd_total - r0, (slot != 0) ? 3 : 0);
        if (slot != 0)
            for (int k = 0; k < 3; k++)
                check(req, "read address", int'(rd_log[(r0 + k) & 15]), slot + k);
        held = ea;
        @(negedge clk);
        check("R10", "done pulse width", int'(done), 0);
        check("R10", "ea held", int'(ea), int'(held));
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; c_hi = '0; c_mid = '0; c_lo = '0;
        repeat (3) @(negedge clk);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "mem_rd in reset", int'(mem_rd), 0);
        check("R1", "ea in reset", int'(ea), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "busy after reset", int'(busy), 0);
    endtask

    task automatic t_plain;
        do_op("R2", 6'h03, 6'h04, 6'h05);
        do_op("R5", 6'h09, 6'h00, 6'h01);
        check("R2", "hand value 345", ref_val(6'h03, 6'h04, 6'h05), 345);
    endtask

    task automatic t_thousands;
        do_op("R3", 6'h39, 6'h09, 6'h39);
        check("R3", "ea top of range", int'(ea), 15999);
        do_op("R3", 6'h11, 6'h02, 6'h23);
        check("R3", "ea mixed zones", int'(ea), 6123);
        do_op("R3", 6'h20, 6'h00, 6'h10);
        check("R3", "ea zones 10/01", int'(ea), 9000);
    endtask

    task automatic t_zero_code;
        do_op("R4", 6'h0A, 6'h0A, 6'h07);
        check("R4", "ea 1010 as zero", int'(ea), 7);
        do_op("R4", 6'h0A, 6'h0A, 6'h0A);
        check("R4", "ea all 1010", int'(ea), 0);
    endtask

    task automatic t_index;
        do_op("R6", 6'h01, 6'h12, 6'h03);
        check("R7", "ea slot1", int'(ea), 373);
        do_op("R7", 6'h25, 6'h20, 6'h06);
        check("R7", "ea slot2 middle zone ignored", int'(ea), 12629);
        do_op("R7", 6'h30, 6'h31, 6'h32);
        check("R7", "ea wrapped", int'(ea), 15011);
    endtask

    task automatic t_busy_ignore;
        int r0 = rd_total;
        c_hi = 6'h01; c_mid = 6'h12; c_lo = 6'h03; start = 1'b1;
        @(negedge clk);
        c_hi = 6'h09; c_mid = 6'h09; c_lo = 6'h09;
        for (int k = 1; k <= 3; k++) begin
            check("R9", "no early done", int'(done), 0);
            check("R8", "busy held", int'(busy), 1);
            @(negedge clk);
        end
        start = 1'b0;
        check("R9", "no early done", int'(done), 0);
        @(negedge clk);
        check("R9", "done after fetch", int'(done), 1);
        check("R9", "ea of first request", int'(ea), 373);
        @(negedge clk);
        check("R9", "no second done", int'(done), 0);
        check("R9", "ea unchanged", int'(ea), 373);
        check("R9", "no extra reads", rd_total - r0, 3);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        set_slot(87, 6'h02, 6'h05, 6'h0A);
        set_slot(92, 6'h11, 6'h32, 6'h03);
        set_slot(97, 6'h39, 6'h09, 6'h39);
        t_reset();
        t_plain();
        t_thousands();
        t_zero_code();
        t_index();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule